// File: doc/BRIEF.md
# Processor External Cycle Sequencer

This block sits between a cached processor core and the external memory path. It takes one access request at a time and turns it into a chain of external bus cycles. There are two kinds of bus cycle. A non-sequential cycle is one preparation (idle) clock followed by a memory phase. A sequential cycle is a memory phase alone. While the bus cycle runs, the block exports a latched address, the type of the current phase and a cycle-clock enable that marks the end of every bus cycle.

A request is either a single word read or a four-word line fill. Either kind may ask for address translation first. The level-1 table read uses the table base and the top twelve virtual address bits. Its descriptor either completes the translation (section), starts a level-2 read (page), or aborts the request (fault). A line fill is one non-sequential cycle followed by three sequential ones at rising word addresses. Every data word is reported as it arrives. A one-clock done pulse comes with the final word, or with the fault flag when the walk aborts.

The memory phase lasts until the memory side raises its ready input, so any number of wait clocks can stretch a bus cycle.

Top module: `ext_cycle_seq`

## Requirements
- R1: While reset is held and on the first clock after it, `cyc_type` is 0 (no cycle), `cyc_clk_en`, `done`, `fault` and `data_valid` are low, and `req_ready` is high.
- R2: A non-sequential cycle shows `cyc_type`=1 (idle) for exactly one clock and then `cyc_type`=2 (memory), both at the same `bus_addr`. `cyc_clk_en` is high in the idle clock and in the final memory clock.
- R3: A sequential cycle shows only `cyc_type`=3 (memory) with no idle clock. It occurs only as words 2 to 4 of a line fill.
- R4: A line fill reads four words. The first address is the physical address with bits [3:0] cleared, in a non-sequential cycle. It is followed by three sequential cycles at +4, +8 and +12. `data_valid` pulses once per word.
- R5: A memory phase holds its type and address until `mem_ready` is high, and `cyc_clk_en` is raised in that phase only on the clock where `mem_ready` is high.
- R6: `bus_addr` changes only on the clock edge that follows a `cyc_clk_en` pulse, or while no cycle is in progress.
- R7: With `req_xlate` set, a non-sequential level-1 read is issued at {`table_base`[31:14], va[31:20], 2'b00}. If the returned descriptor has bits [1:0]=2'b10 (section), the data access uses {desc[31:20], va[19:0]}.
- R8: If the level-1 descriptor has bits [1:0]=2'b01 (page), a non-sequential level-2 read follows at {desc[31:10], va[19:12], 2'b00}. A returned entry with bits [1:0]≠2'b00 gives the data address {entry[31:12], va[11:0]}. An entry with bits [1:0]=2'b00 is a fault.
- R9: A level-1 descriptor with bits [1:0] equal to 2'b00 or 2'b11, or a faulting level-2 entry, ends the request with `done` and `fault` high and no data access issued.
- R10: `done` is a single-clock pulse, one clock after the final memory phase completes. `data_word` then holds the last word read. `req_ready` is low from acceptance until the request has ended.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer free; request taken on this clock |
| req_line | input | 1 | 1: four-word line fill, 0: single word |
| req_xlate | input | 1 | 1: run the translation walk first |
| req_vaddr | input | 32 | Request address (virtual when translating) |
| table_base | input | 32 | Level-1 table base, bits [31:14] used |
| cyc_clk_en | output | 1 | End of the current bus cycle |
| cyc_type | output | 2 | 0 none, 1 idle, 2 non-sequential memory, 3 sequential memory |
| bus_addr | output | 32 | Latched bus address |
| mem_ready | input | 1 | Memory phase may complete |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| data_valid | output | 1 | A data word was read (registered) |
| data_word | output | 32 | Last data word read |
| done | output | 1 | Request finished (one clock) |
| fault | output | 1 | Request ended by a translation fault |

## Verification
The assertions assume that `mem_ready` matters only during a memory phase, and that `mem_rdata` is valid whenever `mem_ready` is high there. They also assume request addresses are word aligned. The bench memory model raises ready only when `cyc_type` shows a memory phase, after a chosen count of wait clocks. It answers from a word function of `bus_addr`, except at the table addresses, where it returns the descriptors set for each vector. Requests are offered only while `req_ready` is high, and all vector addresses have bits [1:0] clear.

// File: rtl/xseq_pkg.sv
// Shared types and field constants for the external cycle sequencer.
// Assumes a 32-bit byte address and 32-bit data words.
package xseq_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    // Bus phase as exported on cyc_type
    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_IDLE = 2'd1,
        PH_NMEM = 2'd2,
        PH_SMEM = 2'd3
    } phase_t;

    // Request walk state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2,
        ST_DATA = 2'd3
    } walk_t;

    // Descriptor type codes in bits [1:0]
    localparam logic [1:0] DESC_PAGE    = 2'b01;
    localparam logic [1:0] DESC_SECTION = 2'b10;
    localparam logic [1:0] ENTRY_FAULT  = 2'b00;
endpackage

// File: rtl/xseq_addr_form.sv
// Translation address formation (pure combinational).
// Builds the level-1 table address, the level-2 table address and the
// two possible physical addresses from a virtual address and a returned
// descriptor. Assumes table bases are naturally aligned; low base bits
// are not used.
module xseq_addr_form
    import xseq_pkg::*;
(
    input  logic [ADDR_W-1:0] va,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [DATA_W-1:0] desc,
    output logic [ADDR_W-1:0] l1_addr,
    output logic [ADDR_W-1:0] l2_addr,
    output logic [ADDR_W-1:0] sect_pa,
    output logic [ADDR_W-1:0] page_pa
);
    logic unused_bits;

    // Field concatenation for each walk step
    always_comb begin
        l1_addr = {tbl_base[31:14], va[31:20], 2'b00};
        l2_addr = {desc[31:10], va[19:12], 2'b00};
        sect_pa = {desc[31:20], va[19:0]};
        page_pa = {desc[31:12], va[11:0]};
    end

    assign unused_bits = ^{tbl_base[13:0]};
endmodule

// File: rtl/xseq_phaser.sv
// Bus phase engine. A launch with seq=0 runs one idle clock and then a
// memory phase; a launch with seq=1 runs the memory phase only. The
// memory phase lasts until mem_ready. The address register loads only
// on a launch, which is accepted while no cycle runs or on the clock a
// cycle ends. Assumes the controller never launches at other times.
module xseq_phaser
    import xseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              launch_seq,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic              mem_ready,
    output phase_t            phase,
    output logic [ADDR_W-1:0] addr,
    output logic              cyc_end,
    output logic              rd_done
);
    phase_t            phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic              in_mem;

    // Memory-phase and end-of-cycle decode
    always_comb begin
        in_mem  = (phase_q == PH_NMEM) || (phase_q == PH_SMEM);
        rd_done = in_mem && mem_ready;
        cyc_end = (phase_q == PH_IDLE) || rd_done;
    end

    // Phase and latched address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_NONE;
            addr_q  <= '0;
        end else if (launch) begin
            phase_q <= launch_seq ? PH_SMEM : PH_IDLE;
            addr_q  <= launch_addr;
        end else begin
            case (phase_q)
                PH_IDLE: phase_q <= PH_NMEM;
                PH_NMEM,
                PH_SMEM: if (mem_ready) phase_q <= PH_NONE;
                default: phase_q <= PH_NONE;
            endcase
        end
    end

    assign phase = phase_q;
    assign addr  = addr_q;

    AST_IDLE_THEN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |=> (phase_q == PH_NMEM && $stable(addr_q))); // R2
    AST_MEM_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mem && !mem_ready) |=> ($stable(phase_q) && $stable(addr_q))); // R5
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q != $past(addr_q)) |-> ($past(cyc_end) || $past(phase_q) == PH_NONE)); // R6
    AST_LAUNCH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (phase_q == PH_NONE || rd_done)); // R6
endmodule

// File: rtl/xseq_ctrl.sv
// Request walk controller. Accepts one request at a time and steps
// through level-1 read, optional level-2 read and the data access(es),
// launching each bus cycle on the clock the previous one completes.
// Line fills are LINE_WORDS words, the first non-sequential and the rest
// sequential, starting at the line-aligned address. Assumes rd_data is
// valid whenever rd_done is high.
module xseq_ctrl
    import xseq_pkg::*;
#(
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_line,
    input  logic              req_xlate,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] table_base,
    input  phase_t            phase,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              req_ready,
    output logic              launch,
    output logic              launch_seq,
    output logic [ADDR_W-1:0] launch_addr,
    output logic              word_valid,
    output logic              last_word,
    output logic              fault_evt
);
    localparam int CW       = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
    localparam int OFF_BITS = $clog2(LINE_WORDS * 4);
    localparam logic [CW-1:0] LAST_IDX = CW'(LINE_WORDS - 1);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFF_BITS) - 1);

    walk_t             st_q, st_d;
    logic [ADDR_W-1:0] va_q;
    logic              line_q;
    logic [CW-1:0]     cnt_q;
    logic              accept;
    logic              line_sel;
    logic [ADDR_W-1:0] va_sel;
    logic [ADDR_W-1:0] l1_addr, l2_addr, sect_pa, page_pa;

    // Use the live request fields while idle, the latched ones after
    always_comb begin
        line_sel = (st_q == ST_IDLE) ? req_line  : line_q;
        va_sel   = (st_q == ST_IDLE) ? req_vaddr : va_q;
    end

    xseq_addr_form u_form (
        .va       (va_sel),
        .tbl_base (table_base),
        .desc     (rd_data),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr),
        .sect_pa  (sect_pa),
        .page_pa  (page_pa)
    );

    // Next walk step and bus cycle launch decision
    always_comb begin
        st_d        = st_q;
        accept      = 1'b0;
        launch      = 1'b0;
        launch_seq  = 1'b0;
        launch_addr = '0;
        word_valid  = 1'b0;
        last_word   = 1'b0;
        fault_evt   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    launch = 1'b1;
                    if (req_xlate) begin
                        launch_addr = l1_addr;
                        st_d        = ST_L1;
                    end else begin
                        launch_addr = line_sel ? (req_vaddr & LINE_MASK) : req_vaddr;
                        st_d        = ST_DATA;
                    end
                end
            end
            ST_L1: begin
                if (rd_done) begin
                    if (rd_data[1:0] == DESC_SECTION) begin
                        launch      = 1'b1;
                        launch_addr = line_sel ? (sect_pa & LINE_MASK) : sect_pa;
                        st_d        = ST_DATA;
                    end else if (rd_data[1:0] == DESC_PAGE) begin
                        launch      = 1'b1;
                        launch_addr = l2_addr;
                        st_d        = ST_L2;
                    end else begin
                        fault_evt = 1'b1;
                        st_d      = ST_IDLE;
                    end
                end
            end
            ST_L2: begin
                if (rd_done) begin
                    if (rd_data[1:0] == ENTRY_FAULT) begin
                        fault_evt = 1'b1;
                        st_d      = ST_IDLE;
                    end else begin
                        launch      = 1'b1;
                        launch_addr = line_sel ? (page_pa & LINE_MASK) : page_pa;
                        st_d        = ST_DATA;
                    end
                end
            end
            default: begin
                if (rd_done) begin
                    word_valid = 1'b1;
                    if (line_q && cnt_q != LAST_IDX) begin
                        launch      = 1'b1;
                        launch_seq  = 1'b1;
                        launch_addr = cur_addr + ADDR_W'(4);
                    end else begin
                        last_word = 1'b1;
                        st_d      = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // Walk state, latched request and line word counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            va_q   <= '0;
            line_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                va_q   <= req_vaddr;
                line_q <= req_line;
            end
            if (launch && launch_seq)
                cnt_q <= cnt_q + CW'(1);
            else if (launch)
                cnt_q <= '0;
        end
    end

    assign req_ready = (st_q == ST_IDLE);

    AST_SEQ_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SMEM) |-> (st_q == ST_DATA && line_q)); // R3
    AST_FILL_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && rd_done && line_q && cnt_q != LAST_IDX) |=> (phase == PH_SMEM)); // R4
    AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_L1 && rd_done && rd_data[1] == rd_data[0]) |=> (st_q == ST_IDLE && phase == PH_NONE)); // R9
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (phase == PH_NONE)); // R10
endmodule

// File: rtl/ext_cycle_seq.sv
// Processor external cycle sequencer, top level. Joins the walk
// controller and the bus phase engine and registers the per-request
// result outputs (word strobe, word, done, fault) one clock after the
// memory phase that produced them.
module ext_cycle_seq
    import xseq_pkg::*;
#(
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_line,
    input  logic              req_xlate,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] table_base,
    output logic              cyc_clk_en,
    output logic [1:0]        cyc_type,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              data_valid,
    output logic [DATA_W-1:0] data_word,
    output logic              done,
    output logic              fault
);
    phase_t            phase;
    logic              launch, launch_seq, rd_done;
    logic [ADDR_W-1:0] launch_addr;
    logic              word_valid, last_word, fault_evt;
    logic              dv_q, done_q, fault_q;
    logic [DATA_W-1:0] word_q;

    xseq_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_line    (req_line),
        .req_xlate   (req_xlate),
        .req_vaddr   (req_vaddr),
        .table_base  (table_base),
        .phase       (phase),
        .cur_addr    (bus_addr),
        .rd_done     (rd_done),
        .rd_data     (mem_rdata),
        .req_ready   (req_ready),
        .launch      (launch),
        .launch_seq  (launch_seq),
        .launch_addr (launch_addr),
        .word_valid  (word_valid),
        .last_word   (last_word),
        .fault_evt   (fault_evt)
    );

    xseq_phaser u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_seq  (launch_seq),
        .launch_addr (launch_addr),
        .mem_ready   (mem_ready),
        .phase       (phase),
        .addr        (bus_addr),
        .cyc_end     (cyc_clk_en),
        .rd_done     (rd_done)
    );

    // Registered result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q    <= 1'b0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            word_q  <= '0;
        end else begin
            dv_q    <= word_valid;
            done_q  <= last_word || fault_evt;
            fault_q <= fault_evt;
            if (word_valid) word_q <= mem_rdata;
        end
    end

    assign cyc_type   = phase;
    assign data_valid = dv_q;
    assign data_word  = word_q;
    assign done       = done_q;
    assign fault      = fault_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R10
    AST_FAULT_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> (done_q && !dv_q)); // R9
endmodule

// File: tb/tb_ext_cycle_seq.sv
module tb_ext_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_line = 1'b0, req_xlate = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] table_base = 32'h0001_C000;
    logic        req_ready, cyc_clk_en, mem_ready, data_valid, done, fault;
    logic [1:0]  cyc_type;
    logic [31:0] bus_addr, mem_rdata, data_word;

    always #2 clk = ~clk;   // 250 MHz

    ext_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_line(req_line), .req_xlate(req_xlate), .req_vaddr(req_vaddr),
        .table_base(table_base), .cyc_clk_en(cyc_clk_en), .cyc_type(cyc_type),
        .bus_addr(bus_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .data_valid(data_valid), .data_word(data_word), .done(done), .fault(fault)
    );

    // Vector fields: [99] xlate, [98] line, [97:96] wait clocks,
    // [95:64] vaddr, [63:32] level-1 descriptor, [31:0] level-2 entry
    localparam int NV = 8;
    localparam logic [99:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 2'd0, 32'h0000_1230, 32'h0, 32'h0},                 // R2 single
        {1'b0, 1'b1, 2'd0, 32'h0004_0038, 32'h0, 32'h0},                 // R3 R4 fill
        {1'b0, 1'b0, 2'd2, 32'h0010_0100, 32'h0, 32'h0},                 // R5 waits
        {1'b1, 1'b0, 2'd0, 32'h1230_5678, 32'h8760_0002, 32'h0},         // R7 section
        {1'b1, 1'b1, 2'd1, 32'h0450_3A4C, 32'h0012_3401, 32'hABCD_E0F2}, // R8 page fill
        {1'b1, 1'b0, 2'd0, 32'h3330_0010, 32'h0000_0000, 32'h0},         // R9 type 00
        {1'b1, 1'b0, 2'd1, 32'h0220_1000, 32'h0040_0C01, 32'h0000_0000}, // R8 entry fault
        {1'b1, 1'b0, 2'd0, 32'h0770_0040, 32'hFFFF_FFFF, 32'h0}          // R9 type 11
    };

    int n_chk = 0, n_bad = 0, cyc = 0;

    // Memory model state for the current vector
    int          cur_wait = 0;
    logic        have_l1 = 1'b0, have_l2 = 1'b0;
    logic [31:0] l1a = '0, l2a = '0, l1d = '0, l2d = '0;
    int          wcnt = 0;

    function automatic logic [31:0] mword(input logic [31:0] a);
        if (have_l1 && a == l1a) return l1d;
        if (have_l2 && a == l2a) return l2d;
        return a ^ 32'h5A5A_0F0F;
    endfunction

    assign mem_ready = cyc_type[1] && (wcnt == cur_wait);
    assign mem_rdata = mword(bus_addr);

    always @(posedge clk) begin
        if (cyc_type[1] && !mem_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
    end

    // Recorder of cycle ends and results (sampled at negedge)
    logic [1:0]  rt [0:15];
    logic [31:0] ra [0:15];
    int          rn = 0, mem_cyc = 0, dv_cnt = 0, addr_viol = 0, done_cnt = 0;
    logic        got_fault = 1'b0;
    logic [31:0] got_word = '0, prev_addr = '0;
    logic        prev_en = 1'b0;
    logic [1:0]  prev_type = 2'd0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc_clk_en && rn < 16) begin
                rt[rn] = cyc_type; ra[rn] = bus_addr; rn = rn + 1;
            end
            if (cyc_type[1]) mem_cyc = mem_cyc + 1;
            if (data_valid) dv_cnt = dv_cnt + 1;
            if (done) begin done_cnt = done_cnt + 1; got_fault = fault; got_word = data_word; end
            if (bus_addr != prev_addr && !(prev_en || prev_type == 2'd0)) addr_viol = addr_viol + 1;
        end
        prev_addr = bus_addr; prev_en = cyc_clk_en; prev_type = cyc_type;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected trace
    logic [1:0]  et [0:15];
    logic [31:0] ea [0:15];
    int          en;

    task automatic push_n(input logic [31:0] a);
        et[en] = 2'd1; ea[en] = a; en++;
        et[en] = 2'd2; ea[en] = a; en++;
    endtask

    task automatic clear_rec();
        rn = 0; mem_cyc = 0; dv_cnt = 0; done_cnt = 0; got_fault = 1'b0; got_word = '0;
    endtask

    task automatic run_vec(input int i, input string tag);
        logic        x, ln, flt;
        logic [31:0] va, pa, last, a0;
        int          nmem, tmo;
        logic        tr_ok;
        x = VEC[i][99]; ln = VEC[i][98]; cur_wait = int'(VEC[i][97:96]);
        va = VEC[i][95:64]; l1d = VEC[i][63:32]; l2d = VEC[i][31:0];
        have_l1 = x; have_l2 = 1'b0; flt = 1'b0; en = 0; pa = va; last = '0;
        if (x) begin
            l1a = {table_base[31:14], va[31:20], 2'b00};
            push_n(l1a);
            if (l1d[1:0] == 2'b10) pa = {l1d[31:20], va[19:0]};
            else if (l1d[1:0] == 2'b01) begin
                l2a = {l1d[31:10], va[19:12], 2'b00}; have_l2 = 1'b1;
                push_n(l2a);
                if (l2d[1:0] == 2'b00) flt = 1'b1;
                else pa = {l2d[31:12], va[11:0]};
            end else flt = 1'b1;
        end
        if (!flt) begin
            if (ln) begin
                a0 = {pa[31:4], 4'h0};
                push_n(a0);
                for (int k = 1; k < 4; k++) begin et[en] = 2'd3; ea[en] = a0 + 32'(4*k); en++; end
                last = mword(a0 + 32'd12);
            end else begin
                push_n(pa);
                last = mword(pa);
            end
        end
        nmem = 0;
        for (int k = 0; k < en; k++) if (et[k][1]) nmem++;
        clear_rec();
        req_valid = 1'b1; req_line = ln; req_xlate = x; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R10 busy"}, 32'(req_ready), 32'd0);
        tmo = 0;
        while (done_cnt == 0 && tmo < 200) begin @(posedge clk); tmo++; end
        @(negedge clk); @(negedge clk);
        tr_ok = (rn == en);
        for (int k = 0; k < en && k < rn; k++) if (rt[k] != et[k] || ra[k] != ea[k]) tr_ok = 1'b0;
        chk(tr_ok, {tag, " cycle trace"}, 32'(rn), 32'(en));
        if (!tr_ok)
            for (int k = 0; k < en; k++)
                $display("  entry %0d got %0d/%h want %0d/%h", k, rt[k], ra[k], et[k], ea[k]);
        chk(done_cnt == 1, {tag, " R10 one done"}, 32'(done_cnt), 32'd1);
        chk(got_fault == flt, {tag, " R9 fault flag"}, 32'(got_fault), 32'(flt));
        if (!flt) chk(got_word == last, {tag, " R10 final word"}, got_word, last);
        chk(dv_cnt == (flt ? 0 : (ln ? 4 : 1)), {tag, " R4 word count"}, 32'(dv_cnt),
            32'(flt ? 0 : (ln ? 4 : 1)));
        chk(mem_cyc == nmem * (cur_wait + 1), {tag, " R5 memory clocks"}, 32'(mem_cyc),
            32'(nmem * (cur_wait + 1)));
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cyc_type == 2'd0 && !cyc_clk_en && !done && !fault && !data_valid,
            "R1 outputs in reset", {28'd0, cyc_type, cyc_clk_en, done}, 32'd0);
        chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cyc_type == 2'd0 && req_ready, "R1 after release", 32'(cyc_type), 32'd0);

        for (int i = 0; i < NV; i++) begin
            case (i)
                0: run_vec(i, "R2 single");
                1: run_vec(i, "R3 R4 fill");
                2: run_vec(i, "R5 stretch");
                3: run_vec(i, "R7 section");
                4: run_vec(i, "R8 page fill");
                5: run_vec(i, "R9 desc00");
                6: run_vec(i, "R8 entry fault");
                default: run_vec(i, "R9 desc11");
            endcase
        end
        chk(addr_viol == 0, "R6 address changes", 32'(addr_viol), 32'd0);

        // Reset in the middle of a stretched line fill returns to R1 state
        cur_wait = 2; have_l1 = 1'b0; have_l2 = 1'b0;
        req_valid = 1'b1; req_line = 1'b1; req_xlate = 1'b0; req_vaddr = 32'h0000_8000;
        @(negedge clk); req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cyc_type == 2'd0 && req_ready && !cyc_clk_en && !done,
            "R1 mid-request reset", 32'(cyc_type), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_vec(0, "R2 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule